// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block is the sending half of an I2C bus master. On a host command it puts a START condition on the bus, shifts out a slave address byte, and then shifts out data bytes one at a time. Each byte uses nine SCL clocks. The ninth clock carries the slave's acknowledge, which the master samples and reports as a flag. At the falling edge of the ninth clock the master raises a one-cycle interrupt. It then keeps SCL low until the host writes the next byte. That write is what releases the master's hold. A stop command given in place of a write ends the transfer with a STOP condition.

SCL and SDA are open-drain. Each line has a pull-low enable output and a line-level input, and both inputs pass through a synchronizer. SCL timing comes from an internal divider tick. Before every high phase the master lets SCL go and waits until the line actually reads high. Only then does it start timing the high phase. A slave can therefore stretch the clock at any bit, and it can also stretch between bytes.

Top module: `i2cm_tx`

## Requirements
- R1: After reset, both pull-low enables are 0, and busy, irq and ack_seen are all 0.
- R2: A cmd_start pulse while idle latches tx_data as the first byte. The master then pulls SDA low while SCL is high (START) before the first SCL low phase.
- R3: The eight bits of each byte leave most-significant bit first. SDA changes only while SCL is low, except for START and STOP.
- R4: On the ninth clock the master releases SDA. At the SCL rising edge of that clock it sets ack_seen to 1 if SDA reads low and to 0 if SDA reads high.
- R5: irq is a one-cycle pulse in the same cycle that the master pulls SCL low to end the ninth clock. It fires after the address byte and after every data byte, whether the slave sent ACK or NACK.
- R6: After the ninth clock, SCL stays pulled low and no further clock is produced until tx_wr. A tx_wr pulse latches tx_data as the next byte and clears ack_seen in the next cycle.
- R7: Before each high phase the master releases SCL and waits for it to read high. Each SCL high period lasts at least DIV cycles measured from that point, so a slave holding SCL low delays the bit, including the first bit of the next byte.
- R8: A cmd_stop pulse while the master holds the bus after a byte drives SDA low, then releases SCL, then releases SDA while SCL is high (STOP). After that, busy returns to 0.
- R9: cmd_start while busy, and tx_wr while a byte is being clocked, have no effect on the bits sent or on the bus conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Pulse: START and send tx_data as the address byte |
| cmd_stop | input | 1 | Pulse: STOP while holding after a byte |
| tx_wr | input | 1 | Pulse: tx_data is the next byte; releases the hold |
| tx_data | input | 8 | Byte to send |
| ack_seen | output | 1 | 1 when the slave drove SDA low on the ninth clock |
| irq | output | 1 | One-cycle end-of-byte pulse |
| busy | output | 1 | Transfer in progress |
| scl_i | input | 1 | SCL line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A wrong bit counter or shift register shows up at the slave model as a wrong received byte. It can also show up as a missing or extra irq, visible within one byte time. A wrong phase order shows as SDA moving while SCL is high, which the slave model counts as a stray START or STOP in that same clock. A hold state that leaks shows up as SCL edges while the host is silent, within one bit time. A stretch-wait that is skipped shows as an SCL high period shorter than DIV cycles.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    localparam int BYTE_W   = 8;
    localparam int XFER_CLK = 9;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_S_SETUP,
        ST_S_HOLD,
        ST_LOW1,
        ST_LOW2,
        ST_RISE,
        ST_HIGH,
        ST_WAITB,
        ST_P_LOW,
        ST_P_RISE,
        ST_P_HIGH,
        ST_P_FREE
    } ctl_st_e;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == LAST);

    always_comb begin
        if (restart)   cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              restart,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              ack_seen,
    output logic              irq,
    output logic              busy,
    output ctl_st_e           state_o
);
    localparam int BC_W = $clog2(XFER_CLK);
    localparam logic [BC_W-1:0] ACK_BIT = BC_W'(XFER_CLK - 1);

    typedef struct packed {
        ctl_st_e           st;
        logic [BC_W-1:0]   bitn;
        logic [BYTE_W-1:0] shreg;
        logic              scl_oe;
        logic              sda_oe;
        logic              ack;
        logic              irq;
    } ctl_regs_t;

    ctl_regs_t d, q;

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                d.scl_oe = 1'b0;
                d.sda_oe = 1'b0;
                if (cmd_start) begin
                    d.shreg = tx_data;
                    d.ack   = 1'b0;
                    d.st    = ST_S_SETUP;
                end
            end
            ST_S_SETUP: if (tick) begin
                d.sda_oe = 1'b1;          // START: SDA falls, SCL high
                d.st     = ST_S_HOLD;
            end
            ST_S_HOLD: if (tick) begin
                d.scl_oe = 1'b1;
                d.bitn   = '0;
                d.st     = ST_LOW1;
            end
            ST_LOW1: if (tick) begin
                // SDA moves only here, SCL has been low for a tick
                d.sda_oe = (q.bitn == ACK_BIT) ? 1'b0 : ~q.shreg[BYTE_W-1];
                d.st     = ST_LOW2;
            end
            ST_LOW2: if (tick) begin
                d.scl_oe = 1'b0;
                d.st     = ST_RISE;
            end
            ST_RISE: if (scl_s) begin
                if (q.bitn == ACK_BIT) d.ack = ~sda_s;
                d.st = ST_HIGH;
            end
            ST_HIGH: if (tick) begin
                d.scl_oe = 1'b1;
                if (q.bitn == ACK_BIT) begin
                    d.irq = 1'b1;
                    d.st  = ST_WAITB;
                end else begin
                    d.bitn  = q.bitn + 1'b1;
                    d.shreg = {q.shreg[BYTE_W-2:0], 1'b0};
                    d.st    = ST_LOW1;
                end
            end
            ST_WAITB: begin
                if (tx_wr) begin
                    d.shreg = tx_data;
                    d.ack   = 1'b0;
                    d.bitn  = '0;
                    d.st    = ST_LOW1;
                end else if (cmd_stop) begin
                    d.sda_oe = 1'b1;
                    d.st     = ST_P_LOW;
                end
            end
            ST_P_LOW: if (tick) begin
                d.scl_oe = 1'b0;
                d.st     = ST_P_RISE;
            end
            ST_P_RISE: if (scl_s) d.st = ST_P_HIGH;
            ST_P_HIGH: if (tick) begin
                d.sda_oe = 1'b0;          // STOP: SDA rises, SCL high
                d.st     = ST_P_FREE;
            end
            ST_P_FREE: if (tick) d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    assign restart = (d.st != q.st);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.bitn   <= '0;
            q.shreg  <= '0;
            q.scl_oe <= 1'b0;
            q.sda_oe <= 1'b0;
            q.ack    <= 1'b0;
            q.irq    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign scl_oe   = q.scl_oe;
    assign sda_oe   = q.sda_oe;
    assign ack_seen = q.ack;
    assign irq      = q.irq;
    assign busy     = (q.st != ST_IDLE);
    assign state_o  = q.st;
endmodule

// File: rtl/i2cm_tx.sv
module i2cm_tx
    import i2cm_pkg::*;
#(
    parameter int DIV    = 125,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              ack_seen,
    output logic              irq,
    output logic              busy,
    input  logic              scl_i,
    output logic              scl_oe,
    input  logic              sda_i,
    output logic              sda_oe
);
    logic    tick, restart, scl_s, sda_s;
    ctl_st_e ctl_state;

    i2cm_tick #(.DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
    );

    i2cm_sync #(.STAGES(SYNC_N)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_s)
    );

    i2cm_sync #(.STAGES(SYNC_N)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_s)
    );

    i2cm_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .scl_s(scl_s), .sda_s(sda_s),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .tx_wr(tx_wr),
        .tx_data(tx_data), .restart(restart), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .ack_seen(ack_seen), .irq(irq), .busy(busy),
        .state_o(ctl_state)
    );
endmodule

// File: rtl/i2cm_tx_chk.sv
module i2cm_tx_chk
    import i2cm_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    tx_wr,
    input logic    cmd_stop,
    input logic    irq,
    input logic    busy,
    input logic    scl_oe,
    input logic    sda_oe,
    input logic    ack_seen,
    input ctl_st_e ctl_state
);
    // R5: end-of-byte pulse is one cycle wide
    a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R5: pulse coincides with SCL being pulled low
    a_r5_irq_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (scl_oe && !$past(scl_oe)));

    // R6: while waiting for the host, SCL stays held low
    a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == ST_WAITB) |-> scl_oe);

    // R6: accepting a byte clears the ACK flag
    a_r6_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_state) == ST_WAITB && $past(tx_wr)) |-> !ack_seen);

    // R3: inside a byte, SDA drive changes only while SCL is held low
    a_r3_sda_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_state == ST_LOW1 || ctl_state == ST_LOW2 || ctl_state == ST_RISE
          || ctl_state == ST_HIGH) && (sda_oe != $past(sda_oe)))
        |-> ($past(scl_oe) && scl_oe));

    // R8: a stop request while waiting begins by pulling SDA low
    a_r8_stop_begin: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_state) == ST_WAITB && $past(cmd_stop) && !$past(tx_wr))
        |-> (sda_oe && scl_oe));

    // R1: idle leaves both lines released
    a_r1_idle_free: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));
endmodule

bind i2cm_tx i2cm_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .cmd_stop(cmd_stop),
    .irq(irq), .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .ack_seen(ack_seen), .ctl_state(ctl_state)
);

// File: tb/sim_i2cm_tx.sv
`timescale 1ns/1ps
module sim_i2cm_tx;
    localparam int DIV      = 4;
    localparam int STRETCH  = 40;
    localparam logic [6:0] SLV = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0, cmd_stop = 1'b0, tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic ack_seen, irq, busy, scl_oe, sda_oe;
    logic sl_scl_low = 1'b0, sl_sda_low = 1'b0;
    wire  scl_l = !(scl_oe || sl_scl_low);
    wire  sda_l = !(sda_oe || sl_sda_low);

    int n_chk = 0, n_err = 0;

    always #2 clk = ~clk;   // 250 MHz

    i2cm_tx #(.DIV(DIV), .SYNC_N(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .tx_wr(tx_wr), .tx_data(tx_data), .ack_seen(ack_seen), .irq(irq),
        .busy(busy), .scl_i(scl_l), .scl_oe(scl_oe), .sda_i(sda_l),
        .sda_oe(sda_oe)
    );

    // ---------------- slave model ----------------
    logic p_scl = 1'b1, p_sda = 1'b1;
    int   n_start = 0, n_stop = 0, n_irq = 0, n_rise = 0, n_short = 0;
    int   bitn = 0, hi_cnt = 0, st_cnt = 0;
    bit   first = 1'b0, stretch_en = 1'b0;
    logic [7:0] sh = 8'h00, rx_byte = 8'h00;

    always @(posedge clk) begin
        if (irq) n_irq++;
        if (scl_l && p_scl && p_sda && !sda_l) begin
            n_start++; bitn = 0; first = 1'b1;
        end
        if (scl_l && p_scl && !p_sda && sda_l) n_stop++;
        if (scl_l) hi_cnt++;
        if (scl_l && !p_scl) begin
            sh = {sh[6:0], sda_l}; bitn++; n_rise++; hi_cnt = 1;
        end
        if (!scl_l && p_scl) begin
            if (hi_cnt < DIV) n_short++;
            if (bitn == 8) begin
                rx_byte = sh;
                sl_sda_low <= first ? (sh[7:1] == SLV) : (sh % 5 != 0);
            end else if (bitn == 9) begin
                sl_sda_low <= 1'b0; bitn = 0; first = 1'b0;
            end
            if (stretch_en && (bitn == 3 || bitn == 0)) begin
                sl_scl_low <= 1'b1; st_cnt = STRETCH;
            end
        end
        if (st_cnt > 0) begin
            st_cnt--;
            if (st_cnt == 0) sl_scl_low <= 1'b0;
        end
        p_scl = scl_l; p_sda = sda_l;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_irq(input string req);
        int t = 0;
        while (!irq && t < 3000) begin @(negedge clk); t++; end
        chk(t < 3000, req, t, 0);
        @(negedge clk);
    endtask

    task automatic pulse_start(input logic [7:0] v);
        tx_data = v; cmd_start = 1'b1; @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic pulse_wr(input logic [7:0] v);
        tx_data = v; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic do_stop();
        int s0 = n_stop, t = 0;
        cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
        while (busy && t < 3000) begin @(negedge clk); t++; end
        chk(n_stop == s0 + 1, "R8 stop seen", n_stop - s0, 1);
        chk(!busy && !scl_oe && !sda_oe, "R8 idle after stop",
            {busy, scl_oe, sda_oe}, 0);
    endtask

    task automatic run_frame(input logic [7:0] addr, input int base, input int cnt,
                             input bit stretch);
        int s0, i0, r0;
        bit exp_a;
        stretch_en = stretch;
        s0 = n_start; i0 = n_irq;
        pulse_start(addr);
        pulse_start(8'hFF);                  // R9: ignored while busy
        wait_irq("R5 irq after address");
        chk(n_start == s0 + 1, "R2 one START", n_start - s0, 1);
        chk(n_irq == i0 + 1, "R5 one irq for address", n_irq - i0, 1);
        chk(rx_byte == addr, "R2 address byte", rx_byte, addr);
        exp_a = (addr[7:1] == SLV);
        chk(ack_seen == exp_a, "R4 address ack", ack_seen, exp_a);
        for (int k = 0; k < cnt; k++) begin
            logic [7:0] v = 8'((base + k * 37) & 255);
            r0 = n_rise;
            repeat (30) @(negedge clk);
            chk(scl_oe && !scl_l && n_rise == r0, "R6 hold low", n_rise - r0, 0);
            i0 = n_irq;
            pulse_wr(v);
            chk(!ack_seen, "R6 ack cleared", ack_seen, 0);
            repeat (20) @(negedge clk);
            pulse_wr(~v);                    // R9: ignored mid-byte
            wait_irq("R5 irq after data");
            chk(n_irq == i0 + 1, "R5 one irq per data byte", n_irq - i0, 1);
            chk(rx_byte == v, "R3 data msb first", rx_byte, v);
            exp_a = (v % 5 != 0);
            chk(ack_seen == exp_a, "R4 data ack", ack_seen, exp_a);
        end
        chk(n_start == s0 + 1, "R9 no stray START", n_start - s0, 1);
        do_stop();
        chk(n_short == 0, "R7 high period", n_short, 0);
    endtask

    // ---------------- watchdog ----------------
    bit done = 1'b0;
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!scl_oe && !sda_oe && !busy && !irq && !ack_seen, "R1 reset state",
            {scl_oe, sda_oe, busy, irq, ack_seen}, 0);
        pulse_wr(8'h3C);                     // R9: write while idle ignored
        repeat (10) @(negedge clk);
        chk(!busy && n_rise == 0, "R9 idle write ignored", busy, 0);
        run_frame({SLV, 1'b0}, 0, 2, 1'b0);
        run_frame({SLV ^ 7'h01, 1'b0}, 5, 1, 1'b0);   // NACK address, R5
        run_frame({SLV, 1'b1}, 1, 40, 1'b1);          // R7 stretching
        for (int f = 0; f < 6; f++)
            run_frame({SLV, 1'b0}, 2 + f * 41, 36, f[0]);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule